// File: doc/BRIEF.md
# Ready-Triggered Converter Acquisition Controller

This block is the host side of a serial link to a sigma-delta converter that has no separate ready pin. The converter signals a finished conversion by pulling its data-out line low, and only while chip select is low. The controller runs the link in SPI mode 3. After reset it sends a long string of ones to put the converter's serial port back in step. It then writes a fixed list of configuration words and settles into a loop. In that loop it lowers chip select, waits for the ready edge, clocks out a read command, clocks in a 24-bit sample with its 8-bit status byte, and raises chip select again.

Each captured sample is stored in offset binary, so the controller flips its top bit and sign-extends it to 32 bits. It then presents the result with a one-cycle strobe. A status byte that carries the error flag counts toward a run of consecutive bad samples. When that run reaches a limit, the controller resynchronises and reconfigures the converter without outside help. A saturating total of error samples and a flag that is high while the converter is being re-initialised are also brought out.

Top module: `acq_ctrl`

## Requirements
- R1: After reset the first frame is exactly 64 clocks with the data-in line high on every bit. It comes before any configuration word, and `reinit_busy` is high during it.
- R2: The link idles in SPI mode 3. `spi_sclk` is high whenever `spi_cs_n` is high, and `spi_mosi` is high whenever no command or register bit is being sent. Data-in changes after a falling clock edge and data-out is sampled on the rising edge.
- R3: Chip select stays low for the whole frame. At least 2*HALF_DIV system cycles pass from the fall of `spi_cs_n` to the first falling clock edge, and from the last rising clock edge to the rise of `spi_cs_n`. One serial clock period is 2*HALF_DIV system cycles.
- R4: After the resync frame, CFG_NUM frames of 24 clocks each send the configuration words. Word 0 sits in the lowest 24 bits of CFG_WORDS and is sent first, most significant bit first.
- R5: In the acquisition loop, no clock edge occurs after chip select falls until a falling edge appears on `spi_miso`. An edge that arrives during the chip-select setup time still counts. The controller then runs one frame of 40 clocks: the command byte 0x44 followed by 32 ones on data-in, while reading 32 bits MSB first. The first 24 of those bits are the sample and the last 8 are the status byte.
- R6: For each read frame, `sample_valid` pulses for exactly one cycle. At the same time `sample_data` equals the 24-bit sample with its MSB inverted, sign-extended to 32 bits. So 0x800000 becomes 0, 0xFFFFFF becomes 0x007FFFFF and 0x000000 becomes 0xFF800000.
- R7: A sample counts as an error only when status bit 6 (mask 0x40) is set. All other status bits have no effect on error counting or recovery.
- R8: After ERR_LIMIT (16) consecutive error samples, the next frame is a resync frame followed by the configuration frames. Then acquisition resumes. A sample without the error flag restarts the consecutive count from zero.
- R9: `err_total` rises by one with every error sample, updating in the same cycle as `sample_valid`. It holds at its all-ones value once it gets there.
- R10: `reinit_busy` is high from reset until the last configuration frame ends, and again from a recovery decision until the configuration is rewritten. It is low throughout every read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | output | 1 | Serial clock to the converter, idles high |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the converter, idles high |
| spi_miso | input | 1 | Shared converter data-out / ready line |
| sample_data | output | 32 | Signed, sign-extended sample |
| sample_valid | output | 1 | One-cycle strobe marking a new sample |
| err_total | output | ERR_W | Saturating count of error samples |
| reinit_busy | output | 1 | High while the converter is resynchronised and configured |

## Verification
The bench models the converter. It decodes every frame from the pins and answers reads only after a varied ready delay, some of which end during the chip-select setup time. A controller that watched the ready line only after setup would hang there, and one that clocked early would break the no-clock-before-ready check. Status bytes with every bit set except bit 6 catch a controller that tests the whole byte. A single good sample between two error bursts catches an error run that is never cleared, because the recovery frame would then come too early. Four full recoveries push the 6-bit error total past its limit, so a wrapping counter shows up as a wrong total.

// File: rtl/acq_pkg.sv
`timescale 1ns/1ps
package acq_pkg;

    typedef enum logic [2:0] {
        S_GAP,
        S_SETUP,
        S_WAIT,
        S_SHIFT,
        S_HOLD
    } seq_state_e;

    typedef enum logic [1:0] {
        K_SYNC,
        K_CFG,
        K_READ
    } frame_kind_e;

    localparam int unsigned SYNC_BITS    = 64;
    localparam int unsigned CFG_BITS     = 24;
    localparam int unsigned CMD_BITS     = 8;
    localparam int unsigned SAMPLE_BITS  = 24;
    localparam int unsigned STATUS_BITS  = 8;
    localparam int unsigned WORD_BITS    = SAMPLE_BITS + STATUS_BITS;
    localparam int unsigned READ_BITS    = CMD_BITS + WORD_BITS;
    localparam int unsigned OUT_BITS     = 32;
    localparam logic [CMD_BITS-1:0] READ_CMD = 8'h44;

endpackage

// File: rtl/acq_tick_gen.sv
`timescale 1ns/1ps
module acq_tick_gen #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/acq_shifter.sv
`timescale 1ns/1ps
module acq_shifter #(
    parameter int unsigned MAX_BITS = 64,
    parameter int unsigned RX_W     = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          start,
    input  logic [$clog2(MAX_BITS+1)-1:0] nbits,
    input  logic [MAX_BITS-1:0]           tx_word,
    input  logic                          miso,
    output logic                          sclk,
    output logic                          mosi,
    output logic                          done,
    output logic [RX_W-1:0]               rx_word
);
    localparam int unsigned CNT_W = $clog2(MAX_BITS + 1);

    typedef struct packed {
        logic                active;
        logic                sclk;
        logic                mosi;
        logic                done;
        logic [CNT_W-1:0]    cnt;
        logic [MAX_BITS-1:0] tx;
        logic [RX_W-1:0]     rx;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (start) begin
            sh_d.active = 1'b1;
            sh_d.cnt    = nbits;
            sh_d.tx     = tx_word;
            sh_d.sclk   = 1'b1;
        end else if (tick) begin
            if (sh_q.active) begin
                if (sh_q.sclk) begin
                    // falling edge: present the next outgoing bit
                    sh_d.sclk = 1'b0;
                    sh_d.mosi = sh_q.tx[MAX_BITS-1];
                    sh_d.tx   = sh_q.tx << 1;
                end else begin
                    // rising edge: capture the incoming bit
                    sh_d.sclk = 1'b1;
                    sh_d.rx   = {sh_q.rx[RX_W-2:0], miso};
                    sh_d.cnt  = sh_q.cnt - 1'b1;
                    if (sh_q.cnt == CNT_W'(1)) begin
                        sh_d.active = 1'b0;
                        sh_d.done   = 1'b1;
                    end
                end
            end else begin
                sh_d.mosi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.sclk <= 1'b1;
            sh_q.mosi <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sclk    = sh_q.sclk;
    assign mosi    = sh_q.mosi;
    assign done    = sh_q.done;
    assign rx_word = sh_q.rx;

    // R5: a frame never ends while no clocking is in progress
    assert_done_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sclk);
endmodule

// File: rtl/acq_sample_fmt.sv
`timescale 1ns/1ps
module acq_sample_fmt #(
    parameter int unsigned IN_W  = 24,
    parameter int unsigned OUT_W = 32
) (
    input  logic [IN_W-1:0]  raw,
    output logic [OUT_W-1:0] value
);
    localparam int unsigned EXT_W = OUT_W - IN_W;

    logic top_bit;

    always_comb begin
        top_bit = ~raw[IN_W-1];
        value   = {{EXT_W{top_bit}}, top_bit, raw[IN_W-2:0]};
    end
endmodule

// File: rtl/acq_ctrl.sv
`timescale 1ns/1ps
module acq_ctrl
    import acq_pkg::*;
#(
    parameter int unsigned HALF_DIV  = 4,
    parameter int unsigned CFG_NUM   = 3,
    parameter logic [CFG_NUM*CFG_BITS-1:0] CFG_WORDS = {24'h28_0207, 24'h20_1F20, 24'h01_A00C},
    parameter logic [STATUS_BITS-1:0] STATUS_ERR_MASK = 8'h40,
    parameter int unsigned ERR_LIMIT = 16,
    parameter int unsigned ERR_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic [31:0]      sample_data,
    output logic             sample_valid,
    output logic [ERR_W-1:0] err_total,
    output logic             reinit_busy
);
    localparam int unsigned MAX_BITS = SYNC_BITS;
    localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);
    localparam int unsigned RUN_W    = $clog2(ERR_LIMIT + 1);
    localparam int unsigned IDX_W    = (CFG_NUM > 1) ? $clog2(CFG_NUM) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CFG_NUM - 1);
    localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(ERR_LIMIT);

    typedef struct packed {
        seq_state_e          state;
        frame_kind_e         kind;
        logic [IDX_W-1:0]    idx;
        logic                tcnt;
        logic                cs_n;
        logic                busy;
        logic [RUN_W-1:0]    run;
        logic [ERR_W-1:0]    errs;
        logic                valid;
        logic [OUT_BITS-1:0] data;
        logic                start;
        logic [CNT_W-1:0]    nbits;
        logic [MAX_BITS-1:0] tx;
        logic                meta;
        logic                sync;
        logic                prev;
        logic                rdy_pend;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                tick;
    logic                sh_done;
    logic [WORD_BITS-1:0] sh_rx;
    logic [OUT_BITS-1:0] fmt_value;
    logic                rdy_fall;
    logic                smp_err;

    acq_tick_gen #(.HALF_DIV(HALF_DIV)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    acq_shifter #(.MAX_BITS(MAX_BITS), .RX_W(WORD_BITS)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (c_q.start),
        .nbits   (c_q.nbits),
        .tx_word (c_q.tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

    acq_sample_fmt #(.IN_W(SAMPLE_BITS), .OUT_W(OUT_BITS)) i_fmt (
        .raw   (sh_rx[WORD_BITS-1 -: SAMPLE_BITS]),
        .value (fmt_value)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        c_d.start = 1'b0;
        c_d.meta  = spi_miso;
        c_d.sync  = c_q.meta;
        c_d.prev  = c_q.sync;
        rdy_fall  = c_q.prev & ~c_q.sync;
        smp_err   = |(sh_rx[STATUS_BITS-1:0] & STATUS_ERR_MASK);

        unique case (c_q.state)
            S_GAP: begin
                if (tick) begin
                    if (c_q.tcnt) begin
                        c_d.tcnt     = 1'b0;
                        c_d.cs_n     = 1'b0;
                        c_d.rdy_pend = 1'b0;
                        c_d.state    = S_SETUP;
                    end else begin
                        c_d.tcnt = 1'b1;
                    end
                end
            end
            S_SETUP: begin
                if (rdy_fall) c_d.rdy_pend = 1'b1;
                if (tick) begin
                    if (c_q.tcnt) begin
                        c_d.tcnt = 1'b0;
                        if (c_q.kind == K_READ) begin
                            c_d.state = S_WAIT;
                        end else begin
                            c_d.state = S_SHIFT;
                            c_d.start = 1'b1;
                            if (c_q.kind == K_SYNC) begin
                                c_d.nbits = CNT_W'(SYNC_BITS);
                                c_d.tx    = '1;
                            end else begin
                                c_d.nbits = CNT_W'(CFG_BITS);
                                c_d.tx    = {CFG_WORDS[int'(c_q.idx)*CFG_BITS +: CFG_BITS],
                                             {(MAX_BITS-CFG_BITS){1'b1}}};
                            end
                        end
                    end else begin
                        c_d.tcnt = 1'b1;
                    end
                end
            end
            S_WAIT: begin
                if (rdy_fall || c_q.rdy_pend) begin
                    c_d.rdy_pend = 1'b0;
                    c_d.state    = S_SHIFT;
                    c_d.start    = 1'b1;
                    c_d.nbits    = CNT_W'(READ_BITS);
                    c_d.tx       = {READ_CMD, {(MAX_BITS-CMD_BITS){1'b1}}};
                end
            end
            S_SHIFT: begin
                if (sh_done) begin
                    c_d.state = S_HOLD;
                    c_d.tcnt  = 1'b0;
                    if (c_q.kind == K_READ) begin
                        c_d.valid = 1'b1;
                        c_d.data  = fmt_value;
                        if (smp_err) begin
                            if (c_q.errs != '1) c_d.errs = c_q.errs + 1'b1;
                            if (c_q.run < RUN_MAX) c_d.run = c_q.run + 1'b1;
                        end else begin
                            c_d.run = '0;
                        end
                    end
                end
            end
            S_HOLD: begin
                if (tick) begin
                    if (c_q.tcnt) begin
                        c_d.tcnt  = 1'b0;
                        c_d.cs_n  = 1'b1;
                        c_d.state = S_GAP;
                        unique case (c_q.kind)
                            K_SYNC: begin
                                c_d.kind = K_CFG;
                                c_d.idx  = '0;
                            end
                            K_CFG: begin
                                if (c_q.idx == LAST_IDX) begin
                                    c_d.kind = K_READ;
                                    c_d.busy = 1'b0;
                                end else begin
                                    c_d.idx = c_q.idx + 1'b1;
                                end
                            end
                            default: begin
                                if (c_q.run >= RUN_MAX) begin
                                    c_d.kind = K_SYNC;
                                    c_d.busy = 1'b1;
                                    c_d.run  = '0;
                                end
                            end
                        endcase
                    end else begin
                        c_d.tcnt = 1'b1;
                    end
                end
            end
            default: c_d.state = S_GAP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= S_GAP;
            c_q.kind  <= K_SYNC;
            c_q.cs_n  <= 1'b1;
            c_q.busy  <= 1'b1;
            c_q.meta  <= 1'b1;
            c_q.sync  <= 1'b1;
            c_q.prev  <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign spi_cs_n     = c_q.cs_n;
    assign sample_data  = c_q.data;
    assign sample_valid = c_q.valid;
    assign err_total    = c_q.errs;
    assign reinit_busy  = c_q.busy;

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_sclk);
    assert_mosi_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_mosi);
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);
    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(err_total));
    assert_err_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_total == {ERR_W{1'b1}}) |=> (err_total == {ERR_W{1'b1}}));
    assert_no_read_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> !reinit_busy);
endmodule

// File: tb/test_acq_ctrl.sv
`timescale 1ns/1ps
module test_acq_ctrl;
    localparam int unsigned HALF  = 2;
    localparam int unsigned NCFG  = 3;
    localparam logic [NCFG*24-1:0] CFGW = {24'h3C_5A81, 24'h12_0F0E, 24'hC7_0033};
    localparam int unsigned LIMIT = 16;
    localparam int unsigned EW    = 6;
    localparam int unsigned EMAX  = (1 << EW) - 1;
    localparam int unsigned NSMP  = 79;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          spi_sclk, spi_cs_n, spi_mosi;
    logic          miso_drv = 1'b1;
    logic [31:0]   sample_data;
    logic          sample_valid;
    logic [EW-1:0] err_total;
    logic          reinit_busy;

    acq_ctrl #(
        .HALF_DIV(HALF), .CFG_NUM(NCFG), .CFG_WORDS(CFGW),
        .STATUS_ERR_MASK(8'h40), .ERR_LIMIT(LIMIT), .ERR_W(EW)
    ) i_acq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso_drv),
        .sample_data(sample_data), .sample_valid(sample_valid),
        .err_total(err_total), .reinit_busy(reinit_busy)
    );

    int compared = 0;
    int mismatched = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] smp_val(input int n);
        case (n)
            0: return 24'h800000;
            1: return 24'h000000;
            2: return 24'hFFFFFF;
            3: return 24'h7FFFFF;
            4: return 24'h123456;
            default: return 24'((n * 32'h0A3D71) ^ 32'h5A5A5A);
        endcase
    endfunction

    function automatic logic [7:0] smp_stat(input int n);
        if (n == 2) return 8'hBF;
        if (n == 4) return 8'h81;
        if (n < 5) return 8'h00;
        if (n < 10) return (n % 2 == 0) ? 8'h40 : 8'hC3;
        if (n == 10) return 8'h00;
        if (n < 75) return (n % 2 == 0) ? 8'hFF : 8'h40;
        return 8'h3F;
    endfunction

    function automatic logic [31:0] to_signed32(input logic [23:0] v);
        longint s;
        s = longint'(v) - 64'sd8388608;
        return s[31:0];
    endfunction

    typedef enum {E_SYNC, E_CFG, E_READ} ek_e;
    ek_e         exp_kind = E_SYNC;
    int          exp_idx = 0;
    bit          recovering = 0;
    logic        prev_cs = 1'b1, prev_sck = 1'b1, prev_valid = 1'b0;
    int          bitcnt = 0, cyc = 0, cs_fall_cyc = 0, last_rise_cyc = 0;
    logic [63:0] fbits = '0;
    bit          first_fall = 0, ready_given = 0;
    int          rdy_wait = 0, smp_idx = 0, err_run = 0, err_model = 0;
    logic [31:0] cur_word = '0;
    logic [31:0] exp_data_q[$];
    int          exp_err_q[$];
    string       exp_tag_q[$];

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (spi_cs_n) begin
                check(spi_sclk === 1'b1, "R2", "sclk idle", spi_sclk, 1);
                check(spi_mosi === 1'b1, "R2", "mosi idle", spi_mosi, 1);
            end
            if (prev_cs && !spi_cs_n) begin
                check(reinit_busy === (exp_kind != E_READ), "R10", "busy at frame start",
                      reinit_busy, exp_kind != E_READ);
                bitcnt = 0; fbits = '0; cs_fall_cyc = cyc; first_fall = 0; rdy_wait = 0;
                ready_given = (exp_kind != E_READ) || (smp_idx >= NSMP);
                if (exp_kind == E_READ && smp_idx < NSMP) begin
                    cur_word = {smp_val(smp_idx), smp_stat(smp_idx)};
                    if (cur_word[6]) begin
                        err_run++;
                        if (err_model < EMAX) err_model++;
                    end else begin
                        err_run = 0;
                    end
                    exp_data_q.push_back(to_signed32(cur_word[31:8]));
                    exp_err_q.push_back(err_model);
                    exp_tag_q.push_back((cur_word[7:0] != 0 && !cur_word[6]) ? "R7" : "R9");
                end
            end else if (!spi_cs_n) begin
                if (!ready_given) begin
                    check(spi_sclk === 1'b1 && spi_mosi === 1'b1, "R5", "quiet before ready",
                          {spi_sclk, spi_mosi}, 3);
                    rdy_wait++;
                    if (rdy_wait == 1 + ((smp_idx * 7) % 23)) begin
                        miso_drv <= 1'b0;
                        ready_given = 1;
                    end
                end
                if (!prev_sck && spi_sclk) begin
                    fbits = {fbits[62:0], spi_mosi};
                    bitcnt++;
                    last_rise_cyc = cyc;
                end
                if (prev_sck && !spi_sclk) begin
                    if (!first_fall) begin
                        first_fall = 1;
                        check(cyc - cs_fall_cyc >= 2 * HALF, "R3", "cs setup cycles",
                              cyc - cs_fall_cyc, 2 * HALF);
                    end
                    if (exp_kind == E_READ && bitcnt >= 8 && bitcnt < 40)
                        miso_drv <= cur_word[31 - (bitcnt - 8)];
                end
            end
            if (!prev_cs && spi_cs_n) begin
                miso_drv <= 1'b1;
                check(cyc - last_rise_cyc >= 2 * HALF, "R3", "cs hold cycles",
                      cyc - last_rise_cyc, 2 * HALF);
                case (exp_kind)
                    E_SYNC: begin
                        check(bitcnt == 64 && fbits == '1, recovering ? "R8" : "R1",
                              "resync frame", bitcnt, 64);
                        exp_kind = E_CFG; exp_idx = 0;
                    end
                    E_CFG: begin
                        check(bitcnt == 24 && fbits[23:0] == CFGW[exp_idx*24 +: 24], "R4",
                              "config frame", fbits[23:0], CFGW[exp_idx*24 +: 24]);
                        exp_idx++;
                        if (exp_idx == NCFG) begin
                            exp_kind = E_READ;
                            recovering = 0;
                        end
                    end
                    default: begin
                        check(bitcnt == 40 && fbits[39:32] == 8'h44 && fbits[31:0] == '1, "R5",
                              "read frame", fbits[39:0], 40'h44FFFFFFFF);
                        smp_idx++;
                        if (err_run == LIMIT) begin
                            err_run = 0;
                            exp_kind = E_SYNC;
                            recovering = 1;
                        end
                    end
                endcase
            end
            if (sample_valid) begin
                check(!prev_valid, "R6", "strobe width", 2, 1);
                if (exp_data_q.size() == 0) begin
                    check(0, "R6", "unexpected strobe", 1, 0);
                end else begin
                    check(sample_data === exp_data_q[0], "R6", "sample value",
                          sample_data, exp_data_q[0]);
                    check(err_total === EW'(exp_err_q[0]), exp_tag_q[0], "error total",
                          err_total, exp_err_q[0]);
                    void'(exp_data_q.pop_front());
                    void'(exp_err_q.pop_front());
                    void'(exp_tag_q.pop_front());
                end
            end
            prev_cs = spi_cs_n;
            prev_sck = spi_sclk;
            prev_valid = sample_valid;
        end
    end

    initial begin
        bit finished;
        finished = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b1 && spi_mosi === 1'b1, "R2",
              "reset pins", {spi_cs_n, spi_sclk, spi_mosi}, 3'b111);
        check(sample_valid === 1'b0 && err_total === '0, "R9", "reset outputs",
              err_total, 0);
        check(reinit_busy === 1'b1, "R10", "busy in reset", reinit_busy, 1);
        rst_n = 1'b1;
        for (int c = 0; c < 150000; c++) begin
            @(negedge clk);
            if (smp_idx >= NSMP && exp_data_q.size() == 0) begin
                finished = 1;
                break;
            end
        end
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R5 watchdog: actual %0d samples expected %0d", smp_idx, NSMP);
        end
        repeat (10) @(negedge clk);
        check(err_total === EW'(EMAX), "R9", "saturated total", err_total, EMAX);
        check(reinit_busy === 1'b0, "R10", "busy after recovery", reinit_busy, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule